// File: doc/BRIEF.md
# Protected flash command decoder

This block sits between a host bus and the back-end of a NOR flash array. It watches single-cycle bus writes, each carrying an address, a 16-bit data word and a write strobe. It recognises the two-write unlock preamble and the command byte that follows it. A fully formed, legal command becomes a one-cycle request to the back-end, carrying an operation code plus the address and data of the write that completed it.

The block also stands in for the array's own timing. A program or an erase holds a busy flag for a fixed number of clock cycles, counted by internal countdown counters. While busy, the decoder ignores every write except an erase-suspend. A suspended erase freezes its counter and releases the bus for reads, for mode changes and for programs outside the suspended region. A resume lets the counter continue from where it stopped.

An active-low write-protect input guards one 32 KWord boot block. A build parameter places that block at the bottom or the top of the address space. When protection is active, programs and erases aimed at the boot block are dropped, and so is every chip erase.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block returns to read mode after that edge: `op_valid`=0, `busy`=0, `suspended`=0 and `mode`=0. Any operation in progress and any suspend are cancelled.
- R2: A program is accepted after four writes: AAh to 555h, 55h to 2AAh, A0h to 555h, then a fourth write that carries the target address and data. One cycle after the fourth write, `op_valid` pulses with `op_code`=1 and the fourth write's address and data. `busy` is then high for exactly PROG_CYC cycles.
- R3: A sector erase is accepted after six writes: AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h, 55h to 2AAh, then 50h at the sector address. The pulse carries `op_code`=2. A final byte of 30h gives a block erase with `op_code`=3. Either erase holds `busy` for ERASE_CYC cycles.
- R4: The same six-write preamble ending with 10h at address 555h is a chip erase. The pulse carries `op_code`=4 and `busy` is held for ERASE_CYC cycles.
- R5: A write that does not match the next expected step of a sequence returns the decoder to idle and is itself discarded. No request is issued, and a fresh sequence must start again from AAh. Command bytes are matched on `wr_data[7:0]`, and the unlock addresses on `wr_addr[10:0]`.
- R6: While `busy` is high, every write is ignored and any partial sequence is dropped. This includes the mode-exit command. The only exception is the suspend byte.
- R7: A single write of B0h at any address during a running sector or block erase is accepted as `op_code`=5. `suspended` rises, `busy` falls and the erase countdown freezes. A single write of 30h while suspended and not programming is accepted as `op_code`=6. `suspended` falls and `busy` stays high for the remaining erase cycles.
- R8: While suspended, a program whose address lies in the suspended sector (address bits above 10) or suspended block (address bits above 14) is rejected. A program elsewhere is accepted.
- R9: When `wp_n` is low, programs and sector or block erases whose address lies in the boot block are ignored, and so is every chip erase. The boot block is block index 0 when BOOT_TOP=0 and the highest block index when BOOT_TOP=1.
- R10: Three-write sequences ending with 90h, 98h or 88h at address 555h set `mode` to 1 (ID), 2 (query) or 3 (secure ID). The operation codes are 7, 8 and 9 respectively. A single write of F0h at any address sets `mode` to 0 with `op_code`=10.
- R11: While suspended, sector, block and chip erase commands are ignored. Suspend is also not accepted while a program is running.
- R12: `op_valid` is high only in the cycle after an accepted write, and never twice for one write. `op_code`, `op_addr` and `op_data` are meaningful only while `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| wp_n | input | 1 | Boot-block write protect, active low |
| op_valid | output | 1 | One-cycle request to the back-end |
| op_code | output | 4 | Requested operation (codes in R2, R3, R4, R7, R10) |
| op_addr | output | ADDR_W | Address of the accepting write |
| op_data | output | DATA_W | Data of the accepting write |
| busy | output | 1 | Program or unsuspended erase in progress |
| suspended | output | 1 | An erase is suspended |
| mode | output | 2 | 0 read, 1 ID, 2 query, 3 secure ID |

## Verification
A decoder stuck mid-sequence shows up on the very next write that should start a fresh sequence: the expected pulse on `op_valid` is missing one cycle after the completing write. A wrong countdown or a lost suspend is visible in the `busy` or `suspended` level, within one cycle of the edge where it goes wrong. A guard that lets a protected or conflicting command through raises a pulse that is not expected. The bench therefore compares every port, on every cycle, against a cycle-level reference model built from the requirements. It drives random command streams biased towards the boot block and the suspended region.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command constants for the protected flash command decoder.
// Assumes command bytes sit in data bits [7:0] and unlock addresses in the
// low eleven address bits.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_PROG   = 4'd1,
        OP_SECT   = 4'd2,
        OP_BLK    = 4'd3,
        OP_CHIP   = 4'd4,
        OP_SUSP   = 4'd5,
        OP_RESUME = 4'd6,
        OP_ID     = 4'd7,
        OP_QUERY  = 4'd8,
        OP_SECID  = 4'd9,
        OP_EXIT   = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ID    = 2'd1,
        MODE_QUERY = 2'd2,
        MODE_SECID = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E3, SQ_E4, SQ_E5
    } seq_e;

    localparam int UNL_W = 11;
    localparam logic [UNL_W-1:0] ADR_KEY_A = 11'h555;
    localparam logic [UNL_W-1:0] ADR_KEY_B = 11'h2AA;

    localparam logic [7:0] CD_KEY1   = 8'hAA;
    localparam logic [7:0] CD_KEY2   = 8'h55;
    localparam logic [7:0] CD_PROG   = 8'hA0;
    localparam logic [7:0] CD_ESETUP = 8'h80;
    localparam logic [7:0] CD_SECT   = 8'h50;
    localparam logic [7:0] CD_BLK    = 8'h30;
    localparam logic [7:0] CD_CHIP   = 8'h10;
    localparam logic [7:0] CD_SUSP   = 8'hB0;
    localparam logic [7:0] CD_RESUME = 8'h30;
    localparam logic [7:0] CD_ID     = 8'h90;
    localparam logic [7:0] CD_QUERY  = 8'h98;
    localparam logic [7:0] CD_SECID  = 8'h88;
    localparam logic [7:0] CD_EXIT   = 8'hF0;

endpackage

// File: rtl/flash_seq_fsm.sv
// Unlock-sequence tracker. Walks the multi-write preambles and offers one
// candidate command per completing write. Assumes the caller holds busy high
// whenever a program or unsuspended erase runs; while busy only the suspend
// byte is offered and the sequence state is dropped.
module flash_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [UNL_W-1:0] addr_lo,
    input  logic [7:0]       cmd,
    input  logic             busy,
    output logic             cand_valid,
    output op_e              cand_op
);

    seq_e seq_q, seq_d;
    logic hit_a, hit_b;

    assign hit_a = (addr_lo == ADR_KEY_A);
    assign hit_b = (addr_lo == ADR_KEY_B);

    // Next-state and candidate decode for the current write.
    always_comb begin
        seq_d      = seq_q;
        cand_valid = 1'b0;
        cand_op    = OP_NONE;
        if (wr_en) begin
            seq_d = SQ_IDLE;
            if (busy) begin
                if (cmd == CD_SUSP) begin
                    cand_valid = 1'b1;
                    cand_op    = OP_SUSP;
                end
            end else begin
                unique case (seq_q)
                    SQ_IDLE: begin
                        if (hit_a && cmd == CD_KEY1) seq_d = SQ_U1;
                        else if (cmd == CD_SUSP) begin
                            cand_valid = 1'b1; cand_op = OP_SUSP;
                        end else if (cmd == CD_RESUME) begin
                            cand_valid = 1'b1; cand_op = OP_RESUME;
                        end else if (cmd == CD_EXIT) begin
                            cand_valid = 1'b1; cand_op = OP_EXIT;
                        end
                    end
                    SQ_U1: if (hit_b && cmd == CD_KEY2) seq_d = SQ_U2;
                    SQ_U2: begin
                        if (hit_a) begin
                            case (cmd)
                                CD_PROG:   seq_d = SQ_PROG;
                                CD_ESETUP: seq_d = SQ_E3;
                                CD_ID:     begin cand_valid = 1'b1; cand_op = OP_ID;    end
                                CD_QUERY:  begin cand_valid = 1'b1; cand_op = OP_QUERY; end
                                CD_SECID:  begin cand_valid = 1'b1; cand_op = OP_SECID; end
                                default:   seq_d = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PROG: begin
                        cand_valid = 1'b1;
                        cand_op    = OP_PROG;
                    end
                    SQ_E3: if (hit_a && cmd == CD_KEY1) seq_d = SQ_E4;
                    SQ_E4: if (hit_b && cmd == CD_KEY2) seq_d = SQ_E5;
                    SQ_E5: begin
                        if (cmd == CD_SECT) begin
                            cand_valid = 1'b1; cand_op = OP_SECT;
                        end else if (cmd == CD_BLK) begin
                            cand_valid = 1'b1; cand_op = OP_BLK;
                        end else if (cmd == CD_CHIP && hit_a) begin
                            cand_valid = 1'b1; cand_op = OP_CHIP;
                        end
                    end
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SQ_IDLE;
        else        seq_q <= seq_d;
    end

    // A running operation always finds the tracker idle.
    assert_seq_idle_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (seq_q == SQ_IDLE));

endmodule

// File: rtl/flash_guard.sv
// Legality filter. Decides whether a candidate command may reach the back-end,
// given the protect pin, the suspend state and the region of the suspended
// erase. Purely combinational; assumes the region inputs come from registers.
module flash_guard
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15,
    parameter bit BOOT_TOP = 1'b0,
    localparam int HI_W    = ADDR_W - SECT_LSB
)(
    input  logic            cand_valid,
    input  op_e             cand_op,
    input  logic [HI_W-1:0] tgt_hi,
    input  logic            wp_n,
    input  logic            susp,
    input  logic            erase_live,
    input  logic            prog_live,
    input  op_e             ekind,
    input  logic [HI_W-1:0] esave_hi,
    output logic            accept
);

    localparam int BOFS = BLK_LSB - SECT_LSB;

    logic boot_hit, sect_same, blk_same, in_susp, locked;

    // Boot block placement picked by the build variant.
    generate
        if (BOOT_TOP) begin : g_top
            assign boot_hit = &tgt_hi[HI_W-1:BOFS];
        end else begin : g_bottom
            assign boot_hit = ~|tgt_hi[HI_W-1:BOFS];
        end
    endgenerate

    assign sect_same = (tgt_hi == esave_hi);
    assign blk_same  = (tgt_hi[HI_W-1:BOFS] == esave_hi[HI_W-1:BOFS]);
    assign in_susp   = susp && ((ekind == OP_SECT) ? sect_same : blk_same);
    assign locked    = !wp_n && boot_hit;

    // Per-command acceptance rule.
    always_comb begin
        accept = 1'b0;
        if (cand_valid) begin
            unique case (cand_op)
                OP_PROG:          accept = !locked && !in_susp;
                OP_SECT, OP_BLK:  accept = !locked && !susp;
                OP_CHIP:          accept = wp_n && !susp;
                OP_SUSP:          accept = erase_live && !susp && !prog_live &&
                                           (ekind == OP_SECT || ekind == OP_BLK);
                OP_RESUME:        accept = susp && !prog_live;
                OP_ID, OP_QUERY, OP_SECID, OP_EXIT: accept = 1'b1;
                default:          accept = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flash_op_ctrl.sv
// Operation controller. Registers accepted requests, runs the program and
// erase countdowns, holds the suspend flag, the suspended region and the
// read mode. Assumes accept is already qualified by the guard.
module flash_op_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int SECT_LSB  = 11,
    parameter int BLK_LSB   = 15,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 48,
    parameter bit BOOT_TOP  = 1'b0,
    localparam int HI_W     = ADDR_W - SECT_LSB
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_n,
    input  logic              accept,
    input  op_e               cand_op,
    output logic              op_valid,
    output op_e               op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              busy,
    output logic              susp,
    output mode_e             mode,
    output logic              erase_live,
    output logic              prog_live,
    output op_e               ekind,
    output logic [HI_W-1:0]   esave_hi
);

    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int BW    = ADDR_W - BLK_LSB;
    localparam logic [BW-1:0] BOOT_IDX = BOOT_TOP ? {BW{1'b1}} : {BW{1'b0}};

    logic [CNT_W-1:0] pcnt_q, ecnt_q;
    logic is_erase;

    assign is_erase   = (cand_op == OP_SECT) || (cand_op == OP_BLK) || (cand_op == OP_CHIP);
    assign prog_live  = (pcnt_q != '0);
    assign erase_live = (ecnt_q != '0);
    assign busy       = prog_live || (erase_live && !susp);

    // Request register towards the back-end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= accept;
            if (accept) begin
                op_code <= cand_op;
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    // Program countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pcnt_q <= '0;
        else if (accept && cand_op == OP_PROG) pcnt_q <= CNT_W'(PROG_CYC);
        else if (prog_live)                  pcnt_q <= pcnt_q - 1'b1;
    end

    // Erase countdown, frozen while suspended; also saves the erase region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt_q   <= '0;
            ekind    <= OP_NONE;
            esave_hi <= '0;
        end else if (accept && is_erase) begin
            ecnt_q   <= CNT_W'(ERASE_CYC);
            ekind    <= cand_op;
            esave_hi <= wr_addr[ADDR_W-1:SECT_LSB];
        end else if (erase_live && !susp) begin
            ecnt_q   <= ecnt_q - 1'b1;
        end
    end

    // Suspend flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                              susp <= 1'b0;
        else if (accept && cand_op == OP_SUSP)   susp <= 1'b1;
        else if (accept && cand_op == OP_RESUME) susp <= 1'b0;
    end

    // Read-mode selection.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_READ;
        else if (accept) begin
            case (cand_op)
                OP_ID:    mode <= MODE_ID;
                OP_QUERY: mode <= MODE_QUERY;
                OP_SECID: mode <= MODE_SECID;
                OP_EXIT:  mode <= MODE_READ;
                default:  mode <= mode;
            endcase
        end
    end

    assert_susp_needs_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> erase_live);

    assert_susp_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && $past(susp)) |-> (ecnt_q == $past(ecnt_q)));

    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy)) |-> (op_code == OP_SUSP));

    assert_prog_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PROG && $past(susp)) |->
        ((ekind == OP_SECT) ? (op_addr[ADDR_W-1:SECT_LSB] != esave_hi)
                            : (op_addr[ADDR_W-1:BLK_LSB] != esave_hi[HI_W-1:BLK_LSB-SECT_LSB])));

    assert_wp_boot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !$past(wp_n) &&
         (op_code == OP_PROG || op_code == OP_SECT || op_code == OP_BLK)) |->
        (op_addr[ADDR_W-1:BLK_LSB] != BOOT_IDX));

    assert_wp_chip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CHIP) |-> $past(wp_n));

    assert_no_erase_in_susp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(susp)) |->
        !(op_code == OP_SECT || op_code == OP_BLK || op_code == OP_CHIP));

endmodule

// File: rtl/flash_cmd_seq.sv
// Protected flash command decoder, top level. Ties the unlock tracker, the
// legality filter and the operation controller together. Assumes one bus
// write per asserted wr_en cycle and a synchronous active-low reset.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int SECT_LSB  = 11,
    parameter int BLK_LSB   = 15,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 48,
    parameter bit BOOT_TOP  = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_n,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              busy,
    output logic              suspended,
    output logic [1:0]        mode
);

    localparam int HI_W = ADDR_W - SECT_LSB;

    logic            cand_valid, accept, erase_live, prog_live;
    op_e             cand_op, op_code_e, ekind;
    mode_e           mode_e_q;
    logic [HI_W-1:0] esave_hi;

    flash_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr_lo    (wr_addr[UNL_W-1:0]),
        .cmd        (wr_data[7:0]),
        .busy       (busy),
        .cand_valid (cand_valid),
        .cand_op    (cand_op)
    );

    flash_guard #(
        .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB), .BOOT_TOP(BOOT_TOP)
    ) u_guard (
        .cand_valid (cand_valid),
        .cand_op    (cand_op),
        .tgt_hi     (wr_addr[ADDR_W-1:SECT_LSB]),
        .wp_n       (wp_n),
        .susp       (suspended),
        .erase_live (erase_live),
        .prog_live  (prog_live),
        .ekind      (ekind),
        .esave_hi   (esave_hi),
        .accept     (accept)
    );

    flash_op_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .BOOT_TOP(BOOT_TOP)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wp_n       (wp_n),
        .accept     (accept),
        .cand_op    (cand_op),
        .op_valid   (op_valid),
        .op_code    (op_code_e),
        .op_addr    (op_addr),
        .op_data    (op_data),
        .busy       (busy),
        .susp       (suspended),
        .mode       (mode_e_q),
        .erase_live (erase_live),
        .prog_live  (prog_live),
        .ekind      (ekind),
        .esave_hi   (esave_hi)
    );

    assign op_code = op_code_e;
    assign mode    = mode_e_q;

endmodule

// File: tb/sim_flash_cmd_seq.sv
// Bench for the protected flash command decoder: directed corner cases and
// seeded random command streams, checked each cycle against a reference model.
module sim_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int PCYC = 6;
    localparam int ECYC = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wp_n = 1'b1;
    logic          op_valid, busy, suspended;
    logic [3:0]    op_code;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    mode;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int m_seq, m_p, m_e, m_ekind, m_mode;
    bit m_susp;
    logic [AW-1:0] m_eaddr;
    bit e_valid;
    int e_code;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    string tag;
    logic [AW-1:0] last_erase;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wp_n(wp_n), .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .busy(busy), .suspended(suspended), .mode(mode)
    );

    function automatic bit m_busy();
        return (m_p != 0) || (m_e != 0 && !m_susp);
    endfunction

    task automatic model_reset();
        m_seq = 0; m_p = 0; m_e = 0; m_susp = 0; m_ekind = 0; m_mode = 0;
        m_eaddr = '0; e_valid = 0; e_code = 0; tag = "R1";
    endtask

    // One clock of the reference model, using the inputs about to be sampled.
    task automatic model_step(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit wp);
        int cand = 0;
        bit ok = 0;
        bit aa = (a[10:0] == 11'h555);
        bit ab = (a[10:0] == 11'h2AA);
        logic [7:0] c = d[7:0];
        bit region;
        bit boot = (a[AW-1:15] == '0);
        int np, ne;
        tag = m_busy() ? "R6" : "R12";
        if (w) begin
            if (m_busy()) begin
                m_seq = 0;
                if (c == 8'hB0) cand = 5;
            end else begin
                case (m_seq)
                    0: begin
                        if (aa && c == 8'hAA) m_seq = 1;
                        else if (c == 8'hB0) cand = 5;
                        else if (c == 8'h30) cand = 6;
                        else if (c == 8'hF0) cand = 10;
                    end
                    1: begin m_seq = (ab && c == 8'h55) ? 2 : 0; if (m_seq == 0) tag = "R5"; end
                    2: begin
                        m_seq = 0;
                        if (aa && c == 8'hA0) m_seq = 3;
                        else if (aa && c == 8'h80) m_seq = 4;
                        else if (aa && c == 8'h90) cand = 7;
                        else if (aa && c == 8'h98) cand = 8;
                        else if (aa && c == 8'h88) cand = 9;
                        else tag = "R5";
                    end
                    3: begin m_seq = 0; cand = 1; end
                    4: begin m_seq = (aa && c == 8'hAA) ? 5 : 0; if (m_seq == 0) tag = "R5"; end
                    5: begin m_seq = (ab && c == 8'h55) ? 6 : 0; if (m_seq == 0) tag = "R5"; end
                    6: begin
                        m_seq = 0;
                        if (c == 8'h50) cand = 2;
                        else if (c == 8'h30) cand = 3;
                        else if (c == 8'h10 && aa) cand = 4;
                        else tag = "R5";
                    end
                    default: m_seq = 0;
                endcase
            end
        end
        region = m_susp && ((m_ekind == 2) ? (a[AW-1:11] == m_eaddr[AW-1:11])
                                           : (a[AW-1:15] == m_eaddr[AW-1:15]));
        case (cand)
            1: begin ok = !(!wp && boot) && !region;
                     tag = (!wp && boot) ? "R9" : (region ? "R8" : "R2"); end
            2, 3: begin ok = !(!wp && boot) && !m_susp;
                     tag = m_susp ? "R11" : ((!wp && boot) ? "R9" : "R3"); end
            4: begin ok = wp && !m_susp; tag = m_susp ? "R11" : (!wp ? "R9" : "R4"); end
            5: begin ok = (m_e != 0) && !m_susp && (m_p == 0) && (m_ekind == 2 || m_ekind == 3);
                     tag = (m_p != 0) ? "R11" : "R7"; end
            6: begin ok = m_susp && (m_p == 0); tag = "R7"; end
            7, 8, 9, 10: begin ok = 1; tag = "R10"; end
            default: ;
        endcase
        np = (m_p != 0) ? m_p - 1 : 0;
        ne = (m_e != 0 && !m_susp) ? m_e - 1 : m_e;
        if (ok) begin
            case (cand)
                1: np = PCYC;
                2, 3, 4: begin ne = ECYC; m_ekind = cand; m_eaddr = a; end
                5: m_susp = 1;
                6: m_susp = 0;
                7: m_mode = 1;
                8: m_mode = 2;
                9: m_mode = 3;
                10: m_mode = 0;
                default: ;
            endcase
        end
        m_p = np; m_e = ne;
        e_valid = ok;
        if (ok) begin e_code = cand; e_addr = a; e_data = d; end
    endtask

    task automatic compare();
        bit bad;
        bad = (op_valid !== e_valid) || (busy !== m_busy()) ||
              (suspended !== m_susp) || (mode !== 2'(m_mode));
        if (e_valid && (op_code !== 4'(e_code) || op_addr !== e_addr || op_data !== e_data))
            bad = 1;
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: got v=%0b code=%0d addr=%h data=%h busy=%0b susp=%0b mode=%0d exp v=%0b code=%0d addr=%h data=%h busy=%0b susp=%0b mode=%0d",
                     tag, op_valid, op_code, op_addr, op_data, busy, suspended, mode,
                     e_valid, e_code, e_addr, e_data, m_busy(), m_susp, m_mode);
        end
    endtask

    // Drive one cycle; inputs set just after a falling edge, outputs checked at the next.
    task automatic tick(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en = w; wr_addr = a; wr_data = d;
        model_step(w, a, d, wp_n);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        tick(1'b1, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, '0);
    endtask

    function automatic logic [AW-1:0] key(logic [10:0] lo);
        return {11'($urandom), lo};
    endfunction

    task automatic unlock();
        wr(key(11'h555), 16'h00AA);
        wr(key(11'h2AA), 16'h0055);
    endtask

    task automatic do_prog(logic [AW-1:0] a, logic [DW-1:0] d);
        unlock(); wr(key(11'h555), 16'h00A0); wr(a, d);
    endtask

    task automatic do_erase(logic [AW-1:0] a, logic [7:0] c);
        unlock(); wr(key(11'h555), 16'h0080); unlock(); wr(a, {8'($urandom), c});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        model_reset();
        n_checks++;
        if (op_valid !== 1'b0 || busy !== 1'b0 || suspended !== 1'b0 || mode !== 2'd0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b busy=%0b susp=%0b mode=%0d exp all zero",
                     op_valid, busy, suspended, mode);
        end
        rst_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] pick_addr();
        case ($urandom % 5)
            0: return {7'd0, 15'($urandom)};
            1: return {last_erase[AW-1:11], 11'($urandom)};
            2: return {last_erase[AW-1:15], 4'($urandom), 11'($urandom)};
            3: return {7'h7F, 15'($urandom)};
            default: return 22'($urandom);
        endcase
    endfunction

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7051));
        last_erase = 22'h012345;
        @(negedge clk);
        do_reset();                                  // R1
        idle(2);
        // R2: program and busy length
        do_prog(22'h2A1234, 16'hBEEF); idle(PCYC + 2);
        // R6: writes during busy, including exit, ignored
        do_prog(22'h100000, 16'h1111); wr(key(11'h555), 16'h00F0); do_prog(22'h100001, 16'h2222); idle(PCYC);
        // R5: aborts mid-sequence
        wr(key(11'h555), 16'h00AA); wr(key(11'h2AB), 16'h0055); wr(key(11'h555), 16'h00A0); wr(22'h3000, 16'h5);
        unlock(); wr(key(11'h555), 16'h0077); idle(1);
        unlock(); wr(key(11'h555), 16'h0080); unlock(); wr(key(11'h554), 16'h0010); idle(2);
        // R3 sector erase, R7 suspend/resume, R8 region checks, R11 erase while suspended
        last_erase = 22'h13C800;
        do_erase(last_erase, 8'h50); idle(5);
        wr(22'h0, 16'h00B0); idle(2);
        do_prog({last_erase[AW-1:11], 11'h7}, 16'h3333); idle(1);
        do_prog({last_erase[AW-1:15], 4'h2, 11'h7}, 16'h4444); idle(PCYC + 1);
        do_erase(22'h200000, 8'h30); do_erase(key(11'h555), 8'h10);
        wr(22'h5, 16'h0030); idle(ECYC + 2);
        // R3 block erase with suspend and in-block program
        last_erase = 22'h2F0000;
        do_erase(last_erase, 8'h30); idle(3); wr(22'h9, 16'h00B0);
        do_prog({last_erase[AW-1:15], 4'h9, 11'h1}, 16'h5555); idle(1);
        wr(22'h9, 16'h0030); idle(ECYC);
        // R4 chip erase; R9 protection
        do_erase(key(11'h555), 8'h10); wr(22'h1, 16'h00B0); idle(ECYC + 1);
        wp_n = 1'b0;
        do_prog(22'h000123, 16'h6666); do_erase(22'h001000, 8'h50); do_erase(22'h000000, 8'h30);
        do_erase(key(11'h555), 8'h10); do_prog(22'h3FFFFF, 16'h7777); idle(PCYC + 1);
        wp_n = 1'b1;
        // R10 modes
        unlock(); wr(key(11'h555), 16'h0090); unlock(); wr(key(11'h555), 16'h0098);
        unlock(); wr(key(11'h555), 16'h0088); wr(22'h3, 16'h00F0);
        // R1 reset cancels busy and suspend
        do_erase(22'h150000, 8'h50); wr(22'h0, 16'h00B0); do_reset(); idle(2);
        // random streams
        for (int it = 0; it < 1500; it++) begin
            if ($urandom % 8 == 0) wp_n = ~wp_n;
            case ($urandom % 14)
                0, 1, 2: do_prog(pick_addr(), 16'($urandom));
                3: begin last_erase = pick_addr(); do_erase(last_erase, 8'h50); end
                4: begin last_erase = pick_addr(); do_erase(last_erase, 8'h30); end
                5: if ($urandom % 4 == 0) do_erase(key(11'h555), 8'h10);
                6, 7: wr(22'($urandom), 16'h00B0);
                8: wr(22'($urandom), 16'h0030);
                9: begin unlock(); wr(key(11'h555), {8'($urandom), (($urandom % 2) != 0) ? 8'h98 : 8'h88}); end
                10: wr(22'($urandom), 16'h00F0);
                11: wr(22'($urandom), 16'($urandom));
                12: begin unlock(); wr(22'($urandom), 16'($urandom)); end
                default: idle(1 + $urandom % 12);
            endcase
        end
        idle(ECYC + PCYC);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule